// File: doc/BRIEF.md
# Power-State LED Blink Controller

This block drives a single standby indicator pin. Two 3-bit mode codes are held outside the block: one for the sleep (S3) state and one for the working (S0) state. A power-state select chooses which code is active. The active code places the pin in one of three conditions. It can sink low continuously. It can be released or driven high, depending on a GPIO drive-enable input. Or it can show one of six slow blink patterns, at 50% or 25% duty, with periods from 1 s to 8 s.

All blink rates come from one free-running counter. The counter advances on a prescaled tick enable, which runs at 8 ticks per second by default, so one 8 s cycle is 64 ticks. The pin value and the output-enable are registered, so both pins change in the clock cycle after the inputs do. Changing the mode or the power state never resets the counter, so the blink phase stays continuous.

Top module: `pwr_led_ctrl`

## Requirements
- R1: When `in_sleep` is 1, the code on `mode_sleep` is active. When `in_sleep` is 0, the code on `mode_work` is active. The two codes are independent.
- R2: Code 000 gives `led_oe`=1 and `led_out`=0, whatever the counter value and `gpio_drv_en` are.
- R3: Code 001 with `gpio_drv_en`=0 gives `led_oe`=0 and `led_out`=0. Code 001 with `gpio_drv_en`=1 gives `led_oe`=1 and `led_out`=1.
- R4: With tick count c, code 011 (1 Hz, 50%) outputs bit 2 of c, and code 010 (0.5 Hz, 50%) outputs bit 3 of c.
- R5: Code 101 (0.25 Hz, 50%) outputs bit 4 of c, and code 100 (0.125 Hz, 50%) outputs bit 5 of c.
- R6: Code 111 (0.25 Hz, 25%) outputs bit 4 AND bit 3 of c. Code 110 (0.125 Hz, 25%) outputs bit 5 AND bit 4 of c.
- R7: A synchronous active-high `rst` clears the tick count to 0 and sets `led_oe`=1 and `led_out`=0 on the next clock edge.
- R8: The count advances by one on each clock edge where `tick_en` is 1. It holds otherwise, and it wraps to 0 after 64 ticks.
- R9: A change of the active code or of `in_sleep` shows on the outputs after the next clock edge. It leaves the tick count unchanged.
- R10: `led_oe` is 1 for every active code other than 001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled timebase enable, one pulse per 1/8 s |
| mode_sleep | input | 3 | Mode code applied in the sleep state |
| mode_work | input | 3 | Mode code applied in the working state |
| in_sleep | input | 1 | Power state: 1 = sleep, 0 = working |
| gpio_drv_en | input | 1 | Chooses drive-high (1) or release (0) for code 001 |
| led_out | output | 1 | Pin output value |
| led_oe | output | 1 | Pin output-enable |

## Verification
Each blink code is sampled at tick counts on both sides of its own tap edge. For example, code 111 is sampled at 23, 24 and 16, which separates the 25% AND from either 50% bit alone. Code 100 is sampled at 31, 32 and 64. These counts catch a wrong tap and a counter that fails to wrap. Static codes are run with `gpio_drv_en` at both levels, to show that only code 001 reacts to it. Each mode vector sets different codes for the two power states, so a swapped selector is exposed. Directed sequences switch modes in the middle of a count, hold the timebase idle, and reset during blinking, to show that the phase is kept, that the count freezes, and that reset clears it.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    typedef enum logic [2:0] {
        LM_SINK       = 3'b000,
        LM_GPIO       = 3'b001,
        LM_HALF_HZ    = 3'b010,
        LM_ONE_HZ     = 3'b011,
        LM_EIGHTH_HZ  = 3'b100,
        LM_QUARTER_HZ = 3'b101,
        LM_EIGHTH_Q   = 3'b110,
        LM_QUARTER_Q  = 3'b111
    } led_mode_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drive_t;

    // Waveforms derived from the tick counter
    typedef struct packed {
        logic sq_1s;      // 1 s period, 50%
        logic sq_2s;      // 2 s period, 50%
        logic sq_4s;      // 4 s period, 50%
        logic sq_8s;      // 8 s period, 50%
        logic pw_4s;      // 4 s period, 25%
        logic pw_8s;      // 8 s period, 25%
    } blink_taps_t;

    localparam pin_drive_t DRIVE_RESET = '{oe: 1'b1, val: 1'b0};

    function automatic led_mode_e to_mode(input logic [2:0] code);
        return led_mode_e'(code);
    endfunction

    function automatic pin_drive_t led_drive(
        input led_mode_e   mode,
        input blink_taps_t taps,
        input logic        gpio_en
    );
        pin_drive_t d;
        d.oe  = 1'b1;
        d.val = 1'b0;
        unique case (mode)
            LM_SINK:       d.val = 1'b0;
            LM_GPIO: begin
                d.oe  = gpio_en;
                d.val = gpio_en;
            end
            LM_HALF_HZ:    d.val = taps.sq_2s;
            LM_ONE_HZ:     d.val = taps.sq_1s;
            LM_EIGHTH_HZ:  d.val = taps.sq_8s;
            LM_QUARTER_HZ: d.val = taps.sq_4s;
            LM_EIGHTH_Q:   d.val = taps.pw_8s;
            LM_QUARTER_Q:  d.val = taps.pw_4s;
            default:       d = DRIVE_RESET;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/led_tick_counter.sv
module led_tick_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (tick_en) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/led_tap_extract.sv
module led_tap_extract
    import led_blink_pkg::*;
#(
    parameter int TICK_LOG2 = 3,
    localparam int CNT_W    = TICK_LOG2 + 3,
    localparam int N_RATES  = 4
) (
    input  logic [CNT_W-1:0] count,
    output blink_taps_t      taps
);
    // sq[k]: square wave with a period of 2^k seconds
    logic [N_RATES-1:0] sq;
    // pw[k]: 25% pulse with a period of 2^k seconds (used for k >= 2)
    logic [N_RATES-1:0] pw;

    for (genvar k = 0; k < N_RATES; k++) begin : g_rate
        assign sq[k] = count[TICK_LOG2 - 1 + k];
        if (k >= 1) begin : g_quarter
            assign pw[k] = count[TICK_LOG2 - 1 + k] & count[TICK_LOG2 - 2 + k];
        end else begin : g_none
            assign pw[k] = 1'b0;
        end
    end

    always_comb begin
        taps.sq_1s = sq[0];
        taps.sq_2s = sq[1];
        taps.sq_4s = sq[2];
        taps.sq_8s = sq[3];
        taps.pw_4s = pw[2];
        taps.pw_8s = pw[3];
    end

    logic unused_pw;
    assign unused_pw = ^pw[1:0];
endmodule

// File: rtl/led_mode_mux.sv
module led_mode_mux
    import led_blink_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code_sleep,
    input  logic [CODE_W-1:0] code_work,
    input  logic              in_sleep,
    output led_mode_e         mode
);
    always_comb begin
        mode = to_mode(in_sleep ? code_sleep : code_work);
    end
endmodule

// File: rtl/pwr_led_ctrl.sv
module pwr_led_ctrl
    import led_blink_pkg::*;
#(
    parameter int TICK_LOG2 = 3,
    parameter int CODE_W    = 3,
    localparam int CNT_W    = TICK_LOG2 + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [CODE_W-1:0] mode_sleep,
    input  logic [CODE_W-1:0] mode_work,
    input  logic              in_sleep,
    input  logic              gpio_drv_en,
    output logic              led_out,
    output logic              led_oe
);
    logic [CNT_W-1:0] tick_cnt;
    blink_taps_t      taps;
    led_mode_e        act_mode;
    pin_drive_t       drive_nxt;
    pin_drive_t       drive_q;

    led_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .count   (tick_cnt)
    );

    led_tap_extract #(.TICK_LOG2(TICK_LOG2)) u_taps (
        .count (tick_cnt),
        .taps  (taps)
    );

    led_mode_mux #(.CODE_W(CODE_W)) u_mux (
        .code_sleep (mode_sleep),
        .code_work  (mode_work),
        .in_sleep   (in_sleep),
        .mode       (act_mode)
    );

    always_comb begin
        drive_nxt = led_drive(act_mode, taps, gpio_drv_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= DRIVE_RESET;
        end else begin
            drive_q <= drive_nxt;
        end
    end

    assign led_out = drive_q.val;
    assign led_oe  = drive_q.oe;
endmodule

// File: rtl/pwr_led_ctrl_chk.sv
module pwr_led_ctrl_chk #(
    parameter int CNT_W  = 6,
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [CODE_W-1:0] mode_sleep,
    input logic [CODE_W-1:0] mode_work,
    input logic              in_sleep,
    input logic              gpio_drv_en,
    input logic              led_out,
    input logic              led_oe,
    input logic [CNT_W-1:0]  cnt
);
    logic              seen;
    logic [CODE_W-1:0] code;

    always_ff @(posedge clk) seen <= !rst;
    assign code = in_sleep ? mode_sleep : mode_work;

    assert_reset_state_R7: assert property (@(posedge clk)
        rst |=> (led_oe && !led_out && cnt == '0));

    assert_sink_low_R2: assert property (@(posedge clk) disable iff (rst)
        (seen && code == 3'b000) |=> (led_oe && !led_out));

    assert_release_R3: assert property (@(posedge clk) disable iff (rst)
        (seen && code == 3'b001 && !gpio_drv_en) |=> !led_oe);

    assert_drive_high_R3: assert property (@(posedge clk) disable iff (rst)
        (seen && code == 3'b001 && gpio_drv_en) |=> (led_oe && led_out));

    assert_oe_on_R10: assert property (@(posedge clk) disable iff (rst)
        (seen && code != 3'b001) |=> led_oe);

    assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (seen && !tick_en) |=> $stable(cnt));

    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (rst)
        (seen && tick_en) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

bind pwr_led_ctrl pwr_led_ctrl_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .mode_sleep  (mode_sleep),
    .mode_work   (mode_work),
    .in_sleep    (in_sleep),
    .gpio_drv_en (gpio_drv_en),
    .led_out     (led_out),
    .led_oe      (led_oe),
    .cnt         (tick_cnt)
);

// File: tb/pwr_led_ctrl_tb.sv
module pwr_led_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic       sleep;
        logic [2:0] m3;
        logic [2:0] m0;
        logic       gpio;
        logic [6:0] n;
        logic       eoe;
        logic       eout;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 3'b000, 3'b011, 1'b0, 7'd12, 1'b1, 1'b0}, // R1 R2 sleep picks S3 code
        '{1'b0, 3'b000, 3'b011, 1'b0, 7'd12, 1'b1, 1'b1}, // R1 R4 work picks S0 code
        '{1'b0, 3'b000, 3'b011, 1'b0, 7'd3,  1'b1, 1'b0}, // R4
        '{1'b0, 3'b000, 3'b010, 1'b0, 7'd8,  1'b1, 1'b1}, // R4
        '{1'b0, 3'b000, 3'b010, 1'b0, 7'd7,  1'b1, 1'b0}, // R4
        '{1'b1, 3'b101, 3'b000, 1'b0, 7'd16, 1'b1, 1'b1}, // R5
        '{1'b1, 3'b101, 3'b000, 1'b0, 7'd15, 1'b1, 1'b0}, // R5
        '{1'b1, 3'b100, 3'b000, 1'b0, 7'd32, 1'b1, 1'b1}, // R5
        '{1'b1, 3'b100, 3'b000, 1'b0, 7'd31, 1'b1, 1'b0}, // R5
        '{1'b1, 3'b111, 3'b000, 1'b0, 7'd24, 1'b1, 1'b1}, // R6
        '{1'b1, 3'b111, 3'b000, 1'b0, 7'd23, 1'b1, 1'b0}, // R6
        '{1'b1, 3'b111, 3'b000, 1'b0, 7'd16, 1'b1, 1'b0}, // R6
        '{1'b0, 3'b000, 3'b110, 1'b0, 7'd48, 1'b1, 1'b1}, // R6
        '{1'b0, 3'b000, 3'b110, 1'b0, 7'd47, 1'b1, 1'b0}, // R6
        '{1'b0, 3'b000, 3'b110, 1'b0, 7'd63, 1'b1, 1'b1}, // R6
        '{1'b1, 3'b001, 3'b000, 1'b0, 7'd5,  1'b0, 1'b0}, // R3 R10 release
        '{1'b1, 3'b001, 3'b000, 1'b1, 7'd5,  1'b1, 1'b1}, // R3 drive high
        '{1'b0, 3'b110, 3'b001, 1'b1, 7'd0,  1'b1, 1'b1}, // R3
        '{1'b1, 3'b100, 3'b000, 1'b0, 7'd64, 1'b1, 1'b0}, // R8 wrap
        '{1'b0, 3'b001, 3'b000, 1'b1, 7'd40, 1'b1, 1'b0}  // R2 gpio ignored
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [2:0] mode_sleep = 3'b000;
    logic [2:0] mode_work = 3'b000;
    logic       in_sleep = 1'b0;
    logic       gpio_drv_en = 1'b0;
    logic       led_out;
    logic       led_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_led_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .mode_sleep  (mode_sleep),
        .mode_work   (mode_work),
        .in_sleep    (in_sleep),
        .gpio_drv_en (gpio_drv_en),
        .led_out     (led_out),
        .led_oe      (led_oe)
    );

    task automatic check(input string req, input logic eoe, input logic eout);
        n_checks++;
        if (led_oe !== eoe || led_out !== eout) begin
            n_fail++;
            $display("FAIL %s: oe/out actual %b/%b expected %b/%b",
                     req, led_oe, led_out, eoe, eout);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // n ticking edges, then one idle edge so the output reflects count n
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        tick_en = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R7: reset state
        check("R7 reset", 1'b1, 1'b0);

        for (int v = 0; v < NV; v++) begin
            do_reset();
            in_sleep    = TBL[v].sleep;
            mode_sleep  = TBL[v].m3;
            mode_work   = TBL[v].m0;
            gpio_drv_en = TBL[v].gpio;
            run(int'(TBL[v].n));
            check($sformatf("table vector %0d", v), TBL[v].eoe, TBL[v].eout);
        end

        // R8: count holds while tick_en is low
        do_reset();
        in_sleep = 1'b0; mode_work = 3'b011; gpio_drv_en = 1'b0;
        run(4);
        idle(30);
        check("R8 hold without tick", 1'b1, 1'b1);

        // R9: mode change mid-count, counter kept
        do_reset();
        in_sleep = 1'b0; mode_work = 3'b011; mode_sleep = 3'b000;
        run(18);
        check("R9 before change (count 18, 1 Hz)", 1'b1, 1'b0);
        mode_work = 3'b101;
        @(negedge clk);
        check("R9 after change (count 18, 0.25 Hz)", 1'b1, 1'b1);
        // R1 R9: power state switch applies the sleep code next edge
        in_sleep = 1'b1;
        @(negedge clk);
        check("R1 R9 state switch to sleep code", 1'b1, 1'b0);
        in_sleep = 1'b0; mode_work = 3'b011;
        run(2);
        check("R9 phase continuous (count 20, 1 Hz)", 1'b1, 1'b1);

        // R7: reset in the middle of blinking clears the count
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R7 outputs after mid-run reset", 1'b1, 1'b0);
        run(3);
        check("R7 count cleared (count 3, 1 Hz)", 1'b1, 1'b0);
        run(1);
        check("R7 count cleared (count 4, 1 Hz)", 1'b1, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule